// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Split HI/LO Accumulator

This execution unit multiplies the low 32 bits of two 64-bit source operands and folds the 64-bit product into an accumulator kept as two 32-bit halves. The upper half is the HI register and the lower half is the LO register. One operation can be issued per cycle. It is selected by a 6-bit function code together with a 5-bit sub-operation code. The available operations are: load the product, load the negated product, add the product to the accumulator, subtract it from the accumulator, or add it with saturation. Each operation comes in a signed form and an unsigned form.

Every accepted operation produces a 64-bit destination value one cycle later. That value is one half of the updated accumulator, sign-extended from 32 bits. A pipeline places this value in a general register, and it sees the new HI/LO contents before the next operation uses them. Code combinations that are not recognised raise a flag and leave the accumulator untouched.

Top module: `mac_hilo`

## Requirements
- R1: After reset, `acc_hi`, `acc_lo`, `done`, `illegal` and `dest` are all zero.
- R2: `done` is high in the cycle after each cycle in which `op_valid` is high, and low otherwise. The updated accumulator and `dest` are valid in that same cycle, so back-to-back operations chain.
- R3: Function `101000` with sub-op `00100`/`01100` (signed) or `00101`/`01101` (unsigned) replaces the accumulator with the 64-bit product.
- R4: Function `101000` with sub-op `00010`/`01010` (signed) or `00011`/`01011` (unsigned) adds the product to the 64-bit accumulator, modulo 2^64.
- R5: Sub-op `00011` or `01011` replaces the accumulator with the negated product. Under function `011000` the product is signed; under function `011001` it is unsigned.
- R6: Subtract-accumulate removes the product from the accumulator. It is signed with function `011000` sub-op `01111`, and unsigned with function `011001` sub-op `01111` or `00111`.
- R7: Function `101000` sub-op `10000`/`11000` adds the signed product to the signed accumulator. A sum above 0x7FFFFFFF becomes 0x000000007FFFFFFF, and a sum below -2^31 becomes 0xFFFFFFFF80000000.
- R8: Function `101000` sub-op `10001`/`11001` adds the unsigned product to the unsigned accumulator. A sum above 0x7FFFFFFF becomes all ones.
- R9: Sub-op bit 3 selects the half returned: 1 gives the new HI, 0 gives the new LO. `dest` is that half sign-extended from bit 31 to 64 bits.
- R10: Any other function/sub-op pair sets `illegal` in the `done` cycle, forces `dest` to zero, and leaves HI and LO unchanged.
- R11: HI and LO keep their values in cycles without `op_valid`.
- R12: Bits 63:32 of both operands have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation issue strobe |
| op_func | input | 6 | Function code |
| op_sub | input | 5 | Sub-operation code |
| src_a | input | 64 | First operand (low 32 bits used) |
| src_b | input | 64 | Second operand (low 32 bits used) |
| done | output | 1 | Result valid, one cycle after issue |
| illegal | output | 1 | Unrecognised code, valid with `done` |
| dest | output | 64 | Sign-extended selected accumulator half |
| acc_hi | output | 32 | HI register (accumulator bits 63:32) |
| acc_lo | output | 32 | LO register (accumulator bits 31:0) |

## Verification
The bench concentrates on the cases where signedness and width decide the answer:
- Signed products of negative operands are checked. A design that zero-extended the operands would return a wrong HI half.
- Operands carry nonzero upper bits. A design that read those bits would return wrong products.
- Saturating sums are driven just past both signed limits and past the unsigned limit. This exposes a clamp that is missing or one-sided, or an unsigned clamp that writes 0x7FFFFFFF instead of all ones.
- Subtract-accumulate across a carry out of LO is checked. A design that treated the halves as independent registers would miss the borrow into HI.
- Illegal codes are issued between legal ones. A decoder that fell through to a default operation would corrupt HI/LO.

// File: rtl/mac_hilo.sv
module mac_hilo #(
  parameter int HALF = 32,
  parameter int OPW  = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [5:0]      op_func,
  input  logic [4:0]      op_sub,
  input  logic [OPW-1:0]  src_a,
  input  logic [OPW-1:0]  src_b,
  output logic            done,
  output logic            illegal,
  output logic [OPW-1:0]  dest,
  output logic [HALF-1:0] acc_hi,
  output logic [HALF-1:0] acc_lo
);
  localparam int ACCW = 2 * HALF;
  localparam logic [5:0] F_MAIN = 6'b101000;
  localparam logic [5:0] F_NEGS = 6'b011000;
  localparam logic [5:0] F_NEGU = 6'b011001;
  localparam logic [ACCW:0] POS_LIM = {{(ACCW-HALF+2){1'b0}}, {(HALF-1){1'b1}}};
  localparam logic [ACCW:0] NEG_LIM = {{(ACCW-HALF+2){1'b1}}, {(HALF-1){1'b0}}};

  typedef enum logic [2:0] {K_LOAD, K_NEG, K_ADD, K_SUB, K_SAT} kind_e;

  kind_e kind;
  logic  legal, sgn;

  always_comb begin
    legal = 1'b1;
    sgn   = 1'b1;
    kind  = K_LOAD;
    unique case (op_func)
      F_MAIN: begin
        unique case ({op_sub[4], op_sub[2:0]})
          4'b0100: begin kind = K_LOAD; sgn = 1'b1; end
          4'b0101: begin kind = K_LOAD; sgn = 1'b0; end
          4'b0010: begin kind = K_ADD;  sgn = 1'b1; end
          4'b0011: begin kind = K_ADD;  sgn = 1'b0; end
          4'b1000: begin kind = K_SAT;  sgn = 1'b1; end
          4'b1001: begin kind = K_SAT;  sgn = 1'b0; end
          default: legal = 1'b0;
        endcase
      end
      F_NEGS, F_NEGU: begin
        sgn = ~op_func[0];
        if (op_sub[4] || !op_sub[1] || !op_sub[0])
          legal = 1'b0;
        else if (!op_sub[2])
          kind = K_NEG;
        else if (op_sub[3] || !sgn)
          kind = K_SUB;
        else
          legal = 1'b0;
      end
      default: legal = 1'b0;
    endcase
  end

  logic [ACCW-1:0] a_ext, b_ext, prod, acc, nxt;
  logic [ACCW:0]   sum_w;
  logic [HALF-1:0] half_v;

  assign a_ext = {{(ACCW-HALF){sgn & src_a[HALF-1]}}, src_a[HALF-1:0]};
  assign b_ext = {{(ACCW-HALF){sgn & src_b[HALF-1]}}, src_b[HALF-1:0]};
  assign prod  = a_ext * b_ext;
  assign acc   = {acc_hi, acc_lo};
  assign sum_w = sgn ? {acc[ACCW-1], acc} + {prod[ACCW-1], prod}
                     : {1'b0, acc} + {1'b0, prod};

  always_comb begin
    unique case (kind)
      K_LOAD: nxt = prod;
      K_NEG:  nxt = -prod;
      K_ADD:  nxt = acc + prod;
      K_SUB:  nxt = acc - prod;
      default: begin
        if (sgn) begin
          if ($signed(sum_w) > $signed(POS_LIM))      nxt = POS_LIM[ACCW-1:0];
          else if ($signed(sum_w) < $signed(NEG_LIM)) nxt = NEG_LIM[ACCW-1:0];
          else                                        nxt = sum_w[ACCW-1:0];
        end else begin
          nxt = (sum_w > POS_LIM) ? {ACCW{1'b1}} : sum_w[ACCW-1:0];
        end
      end
    endcase
  end

  assign half_v = op_sub[3] ? nxt[ACCW-1:HALF] : nxt[HALF-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      illegal <= 1'b0;
      dest    <= '0;
      acc_hi  <= '0;
      acc_lo  <= '0;
    end else begin
      done    <= op_valid;
      illegal <= op_valid & ~legal;
      if (op_valid) begin
        dest <= legal ? {{(OPW-HALF){half_v[HALF-1]}}, half_v} : '0;
        if (legal) begin
          acc_hi <= nxt[ACCW-1:HALF];
          acc_lo <= nxt[HALF-1:0];
        end
      end
    end
  end

  assert_done_follows_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> done);
  assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !done);
  assert_illegal_keeps_acc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !legal) |=> (illegal && $stable(acc_hi) && $stable(acc_lo)));
  assert_idle_keeps_acc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(acc_hi) && $stable(acc_lo)));
  assert_signed_sat_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && legal && kind == K_SAT && sgn) |=> (acc_hi == {HALF{acc_lo[HALF-1]}}));
  assert_unsigned_sat_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && legal && kind == K_SAT && !sgn) |=>
      (acc_hi == '0 || (acc_hi == {HALF{1'b1}} && acc_lo == {HALF{1'b1}})));
endmodule

// File: tb/mac_hilo_tb.sv
module mac_hilo_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [5:0]  op_func = '0;
  logic [4:0]  op_sub = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic        done, illegal;
  logic [63:0] dest;
  logic [31:0] acc_hi, acc_lo;

  int checks = 0, errors = 0;
  logic [31:0] m_hi = '0, m_lo = '0;

  typedef struct {
    logic [63:0] d;
    logic        ill;
    logic [31:0] hi, lo;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  mac_hilo u_dut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_func(op_func),
    .op_sub(op_sub), .src_a(src_a), .src_b(src_b), .done(done), .illegal(illegal),
    .dest(dest), .acc_hi(acc_hi), .acc_lo(acc_lo));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [5:0] f, input logic [4:0] s, input logic [63:0] a, b,
                       output logic [63:0] d, output logic ill);
    logic [63:0] acc, ps, pu, r;
    logic signed [64:0] ss;
    logic [64:0] su;
    longint sa, sbv;
    acc = {m_hi, m_lo};
    sa  = longint'($signed(a[31:0]));
    sbv = longint'($signed(b[31:0]));
    ps  = sa * sbv;
    pu  = {32'b0, a[31:0]} * {32'b0, b[31:0]};
    ill = 1'b0;
    r   = '0;
    case ({f, s})
      {6'b101000, 5'b00100}, {6'b101000, 5'b01100}: r = ps;
      {6'b101000, 5'b00101}, {6'b101000, 5'b01101}: r = pu;
      {6'b101000, 5'b00010}, {6'b101000, 5'b01010}: r = acc + ps;
      {6'b101000, 5'b00011}, {6'b101000, 5'b01011}: r = acc + pu;
      {6'b011000, 5'b00011}, {6'b011000, 5'b01011}: r = 64'd0 - ps;
      {6'b011001, 5'b00011}, {6'b011001, 5'b01011}: r = 64'd0 - pu;
      {6'b011000, 5'b01111}: r = acc - ps;
      {6'b011001, 5'b01111}, {6'b011001, 5'b00111}: r = acc - pu;
      {6'b101000, 5'b10000}, {6'b101000, 5'b11000}: begin
        ss = $signed({acc[63], acc}) + $signed({ps[63], ps});
        if (ss > 65'sd2147483647) r = 64'h0000_0000_7FFF_FFFF;
        else if (ss < -65'sd2147483648) r = 64'hFFFF_FFFF_8000_0000;
        else r = ss[63:0];
      end
      {6'b101000, 5'b10001}, {6'b101000, 5'b11001}: begin
        su = {1'b0, acc} + {1'b0, pu};
        r  = (su > 65'h7FFF_FFFF) ? '1 : su[63:0];
      end
      default: ill = 1'b1;
    endcase
    if (ill) d = '0;
    else begin
      m_hi = r[63:32];
      m_lo = r[31:0];
      d = s[3] ? {{32{r[63]}}, r[63:32]} : {{32{r[31]}}, r[31:0]};
    end
  endtask

  task automatic issue(string tag, logic [5:0] f, logic [4:0] s, logic [63:0] a, b);
    exp_t e;
    @(negedge clk);
    op_valid = 1'b1; op_func = f; op_sub = s; src_a = a; src_b = b;
    model(f, s, a, b, e.d, e.ill);
    e.hi = m_hi; e.lo = m_lo; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_valid = 1'b0;
      src_a = 64'hFFFF_0000_1234_5678; src_b = 64'h55;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: done actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " dest"}, dest, e.d);
        check({e.tag, " illegal"}, {63'b0, illegal}, {63'b0, e.ill});
        check({e.tag, " acc"}, {acc_hi, acc_lo}, {e.hi, e.lo});
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset acc", {acc_hi, acc_lo}, 64'd0);
    check("R1 reset flags", {62'b0, done, illegal}, 64'd0);
    check("R1 reset dest", dest, 64'd0);
    rst_n = 1'b1;
    // R3, R12 signed load, negative operand, junk upper bits
    issue("R3 R12 sload lo", 6'b101000, 5'b00100, 64'hDEAD_BEEF_FFFF_FFFD, 64'hABCD_0000_0000_0005);
    issue("R3 R9 sload hi", 6'b101000, 5'b01100, 64'h0000_0000_8000_0000, 64'h7);
    issue("R3 R9 uload hi", 6'b101000, 5'b01101, 64'h1111_1111_FFFF_FFFF, 64'h2);
    issue("R3 uload lo", 6'b101000, 5'b00101, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
    idle(2);
    check("R11 idle keeps acc", {acc_hi, acc_lo}, {m_hi, m_lo});
    issue("R4 sadd lo", 6'b101000, 5'b00010, 64'hFFFF_FFFF, 64'h3);
    issue("R4 uadd hi", 6'b101000, 5'b01011, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
    issue("R4 sadd hi", 6'b101000, 5'b01010, 64'h8000_0000, 64'h8000_0000);
    issue("R10 illegal main", 6'b101000, 5'b00000, 64'h5, 64'h5);
    issue("R10 illegal neg", 6'b011000, 5'b00111, 64'h5, 64'h5);
    issue("R10 illegal func", 6'b000000, 5'b00100, 64'h5, 64'h5);
    issue("R5 sneg lo", 6'b011000, 5'b00011, 64'hFFFF_FFFE, 64'h9);
    issue("R5 sneg hi", 6'b011000, 5'b01011, 64'h1234_5678, 64'h10);
    issue("R5 uneg lo", 6'b011001, 5'b00011, 64'hFFFF_FFFE, 64'h9);
    issue("R5 uneg hi", 6'b011001, 5'b01011, 64'h8000_0001, 64'h3);
    issue("R3 prep borrow", 6'b101000, 5'b00101, 64'h1_0000_0000, 64'h1);
    issue("R6 usub lo borrow", 6'b011001, 5'b00111, 64'h1, 64'h1);
    issue("R6 usub hi", 6'b011001, 5'b01111, 64'hFFFF_FFFF, 64'h2);
    issue("R6 ssub hi", 6'b011000, 5'b01111, 64'hFFFF_FFFF, 64'h2);
    issue("R3 prep pos", 6'b101000, 5'b00101, 64'h7FFF_FFF0, 64'h1);
    issue("R7 sat pos clamp", 6'b101000, 5'b10000, 64'h100, 64'h1);
    issue("R3 prep neg", 6'b101000, 5'b00100, 64'h8000_0005, 64'h1);
    issue("R7 sat neg clamp hi", 6'b101000, 5'b11000, 64'hFFFF_FF9C, 64'h1);
    issue("R7 sat in range", 6'b101000, 5'b10000, 64'h10, 64'h10);
    issue("R3 prep zero", 6'b101000, 5'b00101, 64'h0, 64'h0);
    issue("R8 usat in range", 6'b101000, 5'b10001, 64'h1000, 64'h10);
    issue("R8 usat ones", 6'b101000, 5'b10001, 64'h8000_0000, 64'h1);
    issue("R3 prep zero2", 6'b101000, 5'b00101, 64'h0, 64'h0);
    issue("R8 usat ones hi", 6'b101000, 5'b11001, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
    idle(3);
    check("R2 queue drained", 64'(sb.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2: watchdog expired actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule